// File: doc/BRIEF.md
# Instruction Fetch Unit with Cache-Miss Restart

This block keeps the fetch address for an in-order pipeline. It looks up each address in a small direct-mapped instruction cache that holds one word per line. When the line holds the addressed word, the instruction goes out in the same cycle with a valid flag, and the fetch address steps forward by one word.

When the lookup misses, the block records the address that missed and raises a stall to the pipeline. It then fetches the word from a slower backing memory through a request/valid handshake whose latency can vary. The returned word is installed in its line, and fetch resumes at the recorded address, which now hits.

A redirect from later pipeline stages, such as a taken branch, replaces the next fetch address. A redirect that arrives while a miss is being serviced is held back. It takes effect once the refill has completed.

Top module: `ifu_fetch_top`

## Requirements
- R1: While reset is asserted, every cache line is invalidated, `instr_valid` and `mem_req` are low and `fetch_stall` is high. After reset, fetch begins at parameter `RESET_PC`, and that first lookup misses.
- R2: A hit occurs when the line selected by address bits [IDX_W+1:2] (IDX_W = log2(LINES)) is valid and its stored tag equals address bits [ADDR_W-1:IDX_W+2]. In a hit cycle, `instr_valid` is high and `instr_word` and `instr_pc` show the cached word and its address. With no redirect, the next fetch address is `instr_pc + 4`.
- R3: In a miss cycle, and in every cycle until the refill completes, `instr_valid` is low and `fetch_stall` is high.
- R4: `mem_req` rises in the cycle after a miss is detected. It stays high, with `mem_addr` unchanged and equal to the word-aligned address that missed, up to and including the cycle in which `mem_rvalid` is high.
- R5: When `mem_rvalid` is high while `mem_req` is high, `mem_rdata` is written into the line of the missed address with that address's tag. In the next cycle, fetch restarts at the missed address, hits, and delivers that word.
- R6: A `redirect_valid` in a hit cycle makes `redirect_pc` the next fetch address.
- R7: A redirect that arrives during a miss or refill is held, and the latest one wins. In the cycle after the refill completes, fetch continues at the held target instead of the missed address, and the refilled line is still installed.
- R8: An address that shares a line with a cached address but has a different tag misses. Its refill evicts the earlier word.
- R9: `mem_rvalid` while `mem_req` is low writes no line and does not change the fetch flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Replace the next fetch address |
| redirect_pc | input | ADDR_W | Redirect target, word aligned |
| instr_valid | output | 1 | Instruction output carries a fetched word |
| instr_word | output | DATA_W | Fetched instruction |
| instr_pc | output | ADDR_W | Address of the fetch in this cycle |
| fetch_stall | output | 1 | Freeze request to the pipeline |
| mem_req | output | 1 | Refill read request to backing memory |
| mem_addr | output | ADDR_W | Refill read address |
| mem_rvalid | input | 1 | Backing memory returns data |
| mem_rdata | input | DATA_W | Returned word |

## Verification
The bench builds the block with LINES = 4 and RESET_PC = 0x40. With only four lines, a short loop refills every line. Straight-line code that runs past 0x4C falls onto line 0 again with a new tag, so evictions and refetches after an eviction happen within a few dozen cycles. The bench varies memory latency from zero to three wait cycles. It injects redirects both in the miss cycle and during a refill, and it returns data when no request is pending.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [0:0] {
    FETCH_RUN    = 1'b0,
    FETCH_REFILL = 1'b1
  } fetch_state_e;

endpackage

// File: rtl/ifu_line_store.sv
module ifu_line_store #(
  parameter int WORD_W = 30,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] look_word,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  input  logic              fill_en,
  input  logic [WORD_W-1:0] fill_word,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = WORD_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_of(input logic [WORD_W-1:0] w);
    return w[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:IDX_W];
  endfunction

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] fill_idx;

  assign look_idx  = line_of(look_word);
  assign fill_idx  = line_of(fill_word);
  assign look_hit  = valid_q[look_idx] && (tag_q[look_idx] == tag_of(look_word));
  assign look_data = data_q[look_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = fill_en && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[i] <= 1'b0;
      else if (sel) valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[i]  <= tag_of(fill_word);
        data_q[i] <= fill_data;
      end
    end
  end

endmodule

// File: rtl/ifu_pc_gen.sv
module ifu_pc_gen #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_pc,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] next_pc(
    input logic [ADDR_W-1:0] cur, input logic do_step,
    input logic do_load, input logic [ADDR_W-1:0] tgt);
    if (do_load) return tgt;
    if (do_step) return cur + STEP_BYTES;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= ADDR_W'(RESET_PC);
    else pc <= next_pc(pc, step, load, load_pc);
  end

endmodule

// File: rtl/ifu_miss_ctrl.sv
module ifu_miss_ctrl
  import ifu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_hit,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              mem_rvalid,
  output logic              deliver,
  output logic              miss_event,
  output logic              refill_done,
  output logic              refill_busy,
  output logic [ADDR_W-3:0] miss_word,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_pc,
  output logic              pc_step,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val
);
  fetch_state_e state_q;

  assign deliver     = (state_q == FETCH_RUN) && look_hit;
  assign miss_event  = (state_q == FETCH_RUN) && !look_hit;
  assign refill_busy = (state_q == FETCH_REFILL);
  assign refill_done = refill_busy && mem_rvalid;

  assign pc_step = deliver;
  assign pc_load = (deliver && redirect_valid) || refill_done;

  always_comb begin
    if (deliver)             pc_load_val = redirect_pc;
    else if (redirect_valid) pc_load_val = redirect_pc;
    else if (pend_valid)     pc_load_val = pend_pc;
    else                     pc_load_val = {miss_word, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FETCH_RUN;
      miss_word <= '0;
    end else if (miss_event) begin
      state_q   <= FETCH_REFILL;
      miss_word <= cur_pc[ADDR_W-1:2];
    end else if (refill_done) begin
      state_q   <= FETCH_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_pc    <= '0;
    end else if (refill_done) begin
      pend_valid <= 1'b0;
    end else if (redirect_valid && !deliver) begin
      pend_valid <= 1'b1;
      pend_pc    <= redirect_pc;
    end
  end

endmodule

// File: rtl/ifu_fetch_top.sv
module ifu_fetch_top #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          LINES    = 16,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr_word,
  output logic [ADDR_W-1:0] instr_pc,
  output logic              fetch_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic              look_hit;
  logic [DATA_W-1:0] look_data;
  logic [ADDR_W-1:0] cur_pc;
  logic              deliver;
  logic              miss_event;
  logic              refill_done;
  logic              refill_busy;
  logic [WORD_W-1:0] miss_word;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_pc;
  logic              pc_step;
  logic              pc_load;
  logic [ADDR_W-1:0] pc_load_val;

  ifu_line_store #(.WORD_W(WORD_W), .DATA_W(DATA_W), .LINES(LINES)) store_i (
    .clk(clk), .rst_n(rst_n),
    .look_word(cur_pc[ADDR_W-1:2]), .look_hit(look_hit), .look_data(look_data),
    .fill_en(refill_done), .fill_word(miss_word), .fill_data(mem_rdata)
  );

  ifu_pc_gen #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) pc_i (
    .clk(clk), .rst_n(rst_n), .step(pc_step), .load(pc_load),
    .load_pc(pc_load_val), .pc(cur_pc)
  );

  ifu_miss_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .look_hit(look_hit), .cur_pc(cur_pc),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .mem_rvalid(mem_rvalid), .deliver(deliver), .miss_event(miss_event),
    .refill_done(refill_done), .refill_busy(refill_busy), .miss_word(miss_word),
    .pend_valid(pend_valid), .pend_pc(pend_pc), .pc_step(pc_step),
    .pc_load(pc_load), .pc_load_val(pc_load_val)
  );

  assign instr_valid = deliver;
  assign instr_word  = look_data;
  assign instr_pc    = cur_pc;
  assign fetch_stall = !deliver;
  assign mem_req     = refill_busy;
  assign mem_addr    = {miss_word, 2'b00};

endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_pc,
  input logic              instr_valid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              miss_event,
  input logic              refill_done,
  input logic              pend_valid,
  input logic [ADDR_W-1:0] pend_pc,
  input logic [ADDR_W-1:0] cur_pc
);

  assert_hit_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !redirect_valid |=> cur_pc == $past(cur_pc) + ADDR_W'(4));

  assert_no_deliver_in_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> !mem_req);

  assert_miss_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_event |=> mem_req);

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_restart_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done && !pend_valid && !redirect_valid |=> instr_valid && cur_pc == $past(mem_addr));

  assert_redirect_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && redirect_valid |=> cur_pc == $past(redirect_pc));

  assert_held_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done && pend_valid && !redirect_valid |=> cur_pc == $past(pend_pc));

endmodule

bind ifu_fetch_top ifu_fetch_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc), .instr_valid(instr_valid), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .miss_event(miss_event),
  .refill_done(refill_done), .pend_valid(pend_valid), .pend_pc(pend_pc),
  .cur_pc(cur_pc)
);

// File: tb/ifu_fetch_top_tb_top.sv
module ifu_fetch_top_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          LN         = 4;
  localparam logic [31:0] RST_PC     = 32'h40;
  localparam int          RUN_CYCLES = 700;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [31:0] instr_pc;
  logic        fetch_stall;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  ifu_fetch_top #(.ADDR_W(32), .DATA_W(32), .LINES(LN), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_pc(instr_pc), .fetch_stall(fetch_stall), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0] + 16'h0101};
  endfunction

  // behavioural reference model
  int          m_state;
  logic [31:0] m_pc, m_miss, m_pend_pc;
  bit          m_pend, m_spur, m_conflict;
  bit          mv   [LN];
  logic [31:0] mtag [LN];
  logic [31:0] mdat [LN];
  string       why_pc, why_word;

  function automatic int idx_of(input logic [31:0] a);
    return int'((a >> 2) % LN);
  endfunction

  function automatic bit model_hit();
    int i = idx_of(m_pc);
    return (m_state == 0) && mv[i] && (mtag[i] == (m_pc >> 4));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pc = RST_PC; m_miss = 0; m_pend = 0; m_pend_pc = 0;
      m_spur = 0; m_conflict = 0; why_pc = "R1"; why_word = "R2";
      for (int i = 0; i < LN; i++) mv[i] = 0;
    end else begin
      m_spur = 0;
      if (m_state == 0) begin
        if (mem_rvalid) m_spur = 1;
        if (model_hit()) begin
          why_word = "R2";
          if (redirect_valid) begin m_pc = redirect_pc; why_pc = "R6"; end
          else begin m_pc = m_pc + 4; why_pc = "R2"; end
        end else begin
          m_conflict = mv[idx_of(m_pc)];
          m_state = 1; m_miss = m_pc;
          if (redirect_valid) begin m_pend = 1; m_pend_pc = redirect_pc; end
        end
      end else if (mem_rvalid) begin
        mv[idx_of(m_miss)]   = 1;
        mtag[idx_of(m_miss)] = m_miss >> 4;
        mdat[idx_of(m_miss)] = mem_rdata;
        why_pc = (redirect_valid || m_pend) ? "R7" : "R5";
        why_word = "R5";
        m_pc = redirect_valid ? redirect_pc : (m_pend ? m_pend_pc : m_miss);
        m_pend = 0; m_state = 0;
      end else if (redirect_valid) begin
        m_pend = 1; m_pend_pc = redirect_pc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit eh = model_hit();
    string lbl = m_spur ? "R9" : (eh ? "R2" : (m_conflict ? "R8" : "R3"));
    chk(instr_valid == eh, lbl, "instr_valid", 32'(instr_valid), 32'(eh));
    chk(fetch_stall == !eh, "R3", "fetch_stall", 32'(fetch_stall), 32'(!eh));
    chk(mem_req == (m_state == 1), "R4", "mem_req", 32'(mem_req), 32'(m_state == 1));
    if (m_state == 1) chk(mem_addr == m_miss, "R4", "mem_addr", mem_addr, m_miss);
    if (eh) begin
      chk(instr_pc == m_pc, why_pc, "instr_pc", instr_pc, m_pc);
      chk(instr_word == mdat[idx_of(m_pc)], why_word, "instr_word",
          instr_word, mdat[idx_of(m_pc)]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat_cnt = 0;
    int nref    = 0;
    int loops   = 0;
    rst_n = 1'b0; redirect_valid = 1'b0; redirect_pc = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) begin
      @(negedge clk);
      // R1: reset state at the ports
      chk(instr_valid == 1'b0, "R1", "instr_valid", 32'(instr_valid), 0);
      chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 0);
      chk(fetch_stall == 1'b1, "R1", "fetch_stall", 32'(fetch_stall), 1);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      compare_all();
      redirect_valid = 1'b0;
      if (instr_valid && instr_pc == 32'h4C && loops < 3) begin
        redirect_valid = 1'b1; redirect_pc = 32'h40; loops++;
      end else if (instr_valid && instr_pc == 32'h68) begin
        redirect_valid = 1'b1; redirect_pc = 32'h44;
      end else if (mem_req && cyc % 7 == 0) begin
        redirect_valid = 1'b1; redirect_pc = 32'h50;
      end else if (!instr_valid && !mem_req && cyc % 5 == 0) begin
        redirect_valid = 1'b1; redirect_pc = 32'h48;
      end
      if (mem_req) begin
        if (lat_cnt == 0) begin
          mem_rvalid = 1'b1; mem_rdata = mem_word(mem_addr);
          nref++; lat_cnt = nref % 4;
        end else begin
          mem_rvalid = 1'b0; lat_cnt--;
        end
      end else begin
        mem_rvalid = (cyc % 11 == 0);
        mem_rdata  = 32'hDEAD0000 | 32'(cyc);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule